// File: doc/BRIEF.md
# Counted Unsigned Multiply-Accumulate Unit

This block sums the products of a fixed-length series of unsigned operand pairs. Two 8-bit operands are presented side by side on separate buses. A load strobe takes each pair into the operand registers. A combinational array multiplier forms the 16-bit product, which is registered. The registered product is then zero-extended and added into a 25-bit running sum.

The unit counts the pairs it has taken. Once the tenth product has been added, it raises a done flag, freezes the sum and refuses further pairs. A synchronous clear zeroes every register and starts a new series. An active-low asynchronous reset does the same at power-up. The caller pulses the load strobe once per pair and reads the sum when done is high.

Top module: `mac_unit`

## Requirements
- R1: `load_i` is sampled on every rising clock edge. A pair is captured on the edge where the previous sample was 1 and the current sample is 0. A pulse of any length therefore captures exactly one pair.
- R2: `prod_o` shows the unsigned product `a_i*b_i` (16 bits) of the captured pair. It is updated one clock edge after the capture edge.
- R3: `sum_o` (25 bits) adds the zero-extended `prod_o` one clock edge after the product update, which is two edges after capture.
- R4: `done_o` goes high on the same edge that adds the tenth product of a series, and not before.
- R5: While `done_o` is high, and once ten pairs have been captured, falling edges of `load_i` are ignored. `prod_o`, `sum_o` and `done_o` keep their values.
- R6: A high `clear_i` at a rising edge zeroes the operands, the product, the sum, the counters and `done_o`. It takes priority over a capture and starts a new series of ten.
- R7: While `rst_ni` is low, `prod_o`, `sum_o` and `done_o` are 0, independent of the clock.
- R8: Ten pairs of 255*255 give a sum of 650250 with no wraparound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear and restart of the series |
| load_i | input | 1 | Load strobe; its falling edge captures a pair |
| a_i | input | 8 | Operand A, unsigned |
| b_i | input | 8 | Operand B, unsigned |
| prod_o | output | 16 | Registered product of the last captured pair |
| sum_o | output | 25 | Running sum of the products |
| done_o | output | 1 | High once ten products have been added |

## Verification
The bench builds the block with its default parameters: 8-bit operands, a 25-bit sum and a series length of ten. This lets it reach the real end of a series, the all-ones worst case at 650250, and the ignored eleventh strobe. A scoreboard predicts each product and running sum at a fixed edge after every strobe's falling edge. Further directed steps check a strobe held high for several cycles, a clear in the middle of a series and a clear after done.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned OP_W_DEF    = 8;
  localparam int unsigned SUM_W_DEF   = 25;
  localparam int unsigned RUN_LEN_DEF = 10;
endpackage

// File: rtl/mac_fall_det.sv
module mac_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fall_o
);
  logic strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign fall_o = strobe_q & ~strobe_i;

  // R1
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/mac_array_mult.sv
module mac_array_mult #(
  parameter int unsigned W = 8,
  localparam int unsigned PW = 2 * W
) (
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  output logic [PW-1:0] p_o
);
  logic [PW-1:0] row [W+1];

  assign row[0] = '0;

  for (genvar i = 0; i < W; i++) begin : g_row
    logic [PW-1:0] pp;
    assign pp         = {{W{1'b0}}, a_i & {W{b_i[i]}}} << i;
    assign row[i+1]   = row[i] + pp;
  end

  assign p_o = row[W];
endmodule

// File: rtl/mac_run_ctrl.sv
module mac_run_ctrl #(
  parameter int unsigned RUN_LEN = 10,
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic fall_i,
  input  logic acc_en_i,
  output logic cap_fire_o,
  output logic done_o
);
  logic [CNT_W-1:0] cap_cnt_q, acc_cnt_q;
  logic             done_q;

  // capture allowed only while pairs remain in this series
  assign cap_fire_o = fall_i & ~clear_i & ~done_q & (cap_cnt_q < CNT_W'(RUN_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_cnt_q <= '0;
      acc_cnt_q <= '0;
      done_q    <= 1'b0;
    end else if (clear_i) begin
      cap_cnt_q <= '0;
      acc_cnt_q <= '0;
      done_q    <= 1'b0;
    end else begin
      if (cap_fire_o) cap_cnt_q <= cap_cnt_q + 1'b1;
      if (acc_en_i) begin
        acc_cnt_q <= acc_cnt_q + 1'b1;
        if (acc_cnt_q == CNT_W'(RUN_LEN - 1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;

  // R4
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(acc_en_i));

  // R5
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !clear_i |=> done_q);
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned OP_W    = OP_W_DEF,
  parameter int unsigned SUM_W   = SUM_W_DEF,
  parameter int unsigned RUN_LEN = RUN_LEN_DEF,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              load_i,
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [PROD_W-1:0] prod_o,
  output logic [SUM_W-1:0]  sum_o,
  output logic              done_o
);
  logic              fall, cap_fire;
  logic [OP_W-1:0]   ra_q, rb_q;
  logic [PROD_W-1:0] mult, prod_q;
  logic [SUM_W-1:0]  sum_q;
  logic              mul_vld_q, acc_vld_q;

  mac_fall_det u_fall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(load_i),
    .fall_o  (fall)
  );

  mac_run_ctrl #(.RUN_LEN(RUN_LEN)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .fall_i    (fall),
    .acc_en_i  (acc_vld_q),
    .cap_fire_o(cap_fire),
    .done_o    (done_o)
  );

  mac_array_mult #(.W(OP_W)) u_mult (
    .a_i(ra_q),
    .b_i(rb_q),
    .p_o(mult)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ra_q      <= '0;
      rb_q      <= '0;
      prod_q    <= '0;
      sum_q     <= '0;
      mul_vld_q <= 1'b0;
      acc_vld_q <= 1'b0;
    end else if (clear_i) begin
      ra_q      <= '0;
      rb_q      <= '0;
      prod_q    <= '0;
      sum_q     <= '0;
      mul_vld_q <= 1'b0;
      acc_vld_q <= 1'b0;
    end else begin
      mul_vld_q <= cap_fire;
      acc_vld_q <= mul_vld_q;
      if (cap_fire) begin
        ra_q <= a_i;
        rb_q <= b_i;
      end
      if (mul_vld_q) prod_q <= mult;
      if (acc_vld_q) sum_q <= sum_q + {{(SUM_W-PROD_W){1'b0}}, prod_q};
    end
  end

  assign prod_o = prod_q;
  assign sum_o  = sum_q;

  // R2
  prod_after_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(prod_q) && !$past(clear_i) |-> $past(mul_vld_q));

  // R5
  sum_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !clear_i |=> $stable(sum_q) && $stable(prod_q));

  // R6
  clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> sum_q == '0 && prod_q == '0 && !done_o);

  // R8
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(clear_i) |-> sum_q >= $past(sum_q));
endmodule

// File: tb/sim_mac_unit.sv
`timescale 1ns/1ps
module sim_mac_unit;
  typedef struct {
    int unsigned due;
    int unsigned prod;
    int unsigned sum;
    bit          done;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clear_i = 1'b0;
  logic        load_i = 1'b0;
  logic [7:0]  a_i = '0, b_i = '0;
  logic [15:0] prod_o;
  logic [24:0] sum_o;
  logic        done_o;

  int unsigned cyc = 0;
  int          n_run = 0, n_fail = 0;
  exp_t        sb[$];

  int unsigned m_sum = 0, m_prod = 0, m_cnt = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mac_unit u0 (
    .clk_i  (clk),
    .rst_ni (rst_ni),
    .clear_i(clear_i),
    .load_i (load_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_o),
    .sum_o  (sum_o),
    .done_o (done_o)
  );

  task automatic check(string req, string what, int unsigned act, int unsigned exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pop items whose due cycle has come
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, "prod", prod_o, e.prod);
      check(e.req, "sum", sum_o, e.sum);
      check(e.req, "done", done_o, e.done);
    end
  end

  // driver: one strobe of `hold` high cycles, falling edge at negedge n
  task automatic pair(input logic [7:0] a, input logic [7:0] b, input int hold, input string req);
    exp_t e;
    @(negedge clk);
    a_i = a; b_i = b; load_i = 1'b1;
    repeat (hold) @(negedge clk);
    load_i = 1'b0;
    if (m_cnt < 10) begin
      m_prod = a * b;
      m_sum  = m_sum + m_prod;
      m_cnt++;
    end
    e.due  = cyc + 3;
    e.prod = m_prod;
    e.sum  = m_sum;
    e.done = (m_cnt == 10);
    e.req  = req;
    sb.push_back(e);
    repeat (4) @(negedge clk);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    m_sum = 0; m_prod = 0; m_cnt = 0;
    // R6
    check("R6", "prod", prod_o, 0);
    check("R6", "sum", sum_o, 0);
    check("R6", "done", done_o, 0);
  endtask

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #12;
    // R7
    check("R7", "prod", prod_o, 0);
    check("R7", "sum", sum_o, 0);
    check("R7", "done", done_o, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;

    // R1 R2 R3 R4: random series of ten
    for (int i = 0; i < 10; i++)
      pair(8'($urandom), 8'($urandom), 1, (i == 9) ? "R4" : "R3");
    // R5: eleventh strobe ignored
    pair(8'd17, 8'd33, 1, "R5");
    pair(8'd255, 8'd2, 3, "R5");

    // R6: clear after done, then a partial series cleared mid-run
    do_clear();
    for (int i = 0; i < 4; i++) pair(8'($urandom), 8'($urandom), 1, "R2");
    do_clear();

    // R1: long strobes capture once each
    for (int i = 0; i < 3; i++) pair(8'(i + 3), 8'(i + 7), 6, "R1");
    do_clear();

    // R8: all-ones worst case
    for (int i = 0; i < 10; i++) pair(8'hFF, 8'hFF, 1, "R8");
    check("R8", "sum", sum_o, 650250);
    check("R8", "done", done_o, 1);
    pair(8'h01, 8'h01, 2, "R5");

    // R6: clear takes priority over a falling strobe at the same edge
    @(negedge clk);
    load_i = 1'b1; a_i = 8'd9; b_i = 8'd9;
    @(negedge clk);
    load_i = 1'b0; clear_i = 1'b1;
    @(negedge clk);
    clear_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R6", "prod", prod_o, 0);
    check("R6", "sum", sum_o, 0);
    m_sum = 0; m_prod = 0; m_cnt = 0;
    pair(8'd12, 8'd12, 1, "R6");

    repeat (3) @(negedge clk);
    check("R3", "scoreboard drained", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule